// File: doc/BRIEF.md
# Linked-List DMA Channel

This block is a single DMA channel that takes its work from a chain of descriptors held in memory. A start pulse hands it the address of the first descriptor. The channel reads the seven words of that descriptor over a word-wide read port. It then moves data units between a memory buffer and a fixed peripheral address: it reads each unit from the source port and writes it to the destination port. When a descriptor is finished, the channel raises an interrupt pulse if the descriptor asks for one. It then follows the descriptor's next pointer, or goes idle.

Every descriptor starts on a 64-byte boundary. A chain whose last next pointer leads back to its first descriptor forms a ring that runs until a stop pulse arrives. This gives cyclic buffers that interrupt once per period. A stop pulse lets the unit in flight finish and then parks the channel.

Top module: `lldma_chan`

## Requirements
- R1: A descriptor is fetched as seven word reads at byte offsets 0, 4, 8, 12, 16, 20 and 24 from its base. The words are, in that order: next pointer, source address, destination address, length, stride, cycles, command. Bits 5:0 of any descriptor address are ignored.
- R2: When command bit 12 is set, each unit is read on the memory port at the source address and then written on the device port at the destination address. When bit 12 is clear, each unit is read on the device port at the source address and written on the memory port at the destination address. The value written equals the value just read.
- R3: The length word gives the number of units per block. The memory address steps by 1, 2 or 4 bytes per unit for unitSize codes 0, 1 and 2; code 3 steps by 4. The device address never changes within a descriptor.
- R4: The cycles word gives the number of blocks, and a value of 0 counts as 1. After each block except the last, the memory address advances by the stride word, in bytes, on top of the unit step.
- R5: A descriptor whose length is 0 makes no data access, but it still completes.
- R6: After a descriptor completes, the channel fetches the descriptor at next-pointer bits 31:6 when next-pointer bit 0 is 1. When that bit is 0, the channel goes idle.
- R7: A ring of valid next pointers is traversed without end, with one completion per descriptor visit.
- R8: On completion, irq is high for exactly one cycle when command bit 1 is 1 and command bit 0 is 0. Otherwise irq stays low.
- R9: A stop pulse while busy takes effect at the end of the current unit or descriptor word. The channel goes idle with no further fetch. An unfinished descriptor gives no interrupt.
- R10: A start pulse while busy is ignored. A stop pulse while idle is ignored and leaves nothing pending.
- R11: After reset the channel is idle, with busy, irq and all request outputs low.
- R12: A request holds its address and its write flag until it is acknowledged. The memory port and the device port are never requested in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begin a chain at startAddr |
| stopPulse | input | 1 | Park the channel at the next boundary |
| startAddr | input | 32 | Address of the first descriptor |
| unitSize | input | 2 | Unit width code: 0 = 1 B, 1 = 2 B, 2 or 3 = 4 B |
| busy | output | 1 | Channel is active |
| irq | output | 1 | One-cycle completion pulse |
| descRdReq | output | 1 | Descriptor word read request |
| descRdAddr | output | 32 | Descriptor word address |
| descRdValid | input | 1 | Descriptor word returned this cycle |
| descRdData | input | 32 | Descriptor word |
| memReq | output | 1 | Memory port request |
| memWe | output | 1 | Memory port write (else read) |
| memAddr | output | 32 | Memory byte address |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, valid with memAck |
| memAck | input | 1 | Memory access done |
| devReq | output | 1 | Device port request |
| devWe | output | 1 | Device port write (else read) |
| devAddr | output | 32 | Device address |
| devWdata | output | 32 | Device write data |
| devRdata | input | 32 | Device read data, valid with devAck |
| devAck | input | 1 | Device access done |

## Verification
The hold properties assume that the descriptor, memory and device responders raise valid or ack for one cycle only, and only while the matching request is high. They never answer twice for one request. The bench models all three ports with responders that answer one cycle after they see an unanswered request, and then drop the answer. This stays inside that assumption for every descriptor chain, ring and stop timing the bench uses.

// File: rtl/lldma_pkg.sv
package lldma_pkg;
  localparam int WORD_W       = 32;
  localparam int DESC_WORDS   = 7;
  localparam int ALIGN_BITS   = 6;
  localparam int IDX_W        = 3;
  localparam int CMD_TODEV    = 12;
  localparam int CMD_IRQ_REQ  = 1;
  localparam int CMD_IRQ_MASK = 0;
  localparam int NEXT_OK      = 0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_CHECK, ST_READ, ST_WRITE, ST_DONE
  } chanState_t;

  typedef struct packed {
    logic loadBase;
    logic loadNext;
    logic capWord;
    logic capData;
    logic stepUnit;
  } dpStrobe_t;

  typedef struct packed {
    logic lastWord;
    logic noUnits;
    logic lastUnit;
    logic lastBlock;
    logic toDev;
    logic irqEn;
    logic nextValid;
  } dpStatus_t;
endpackage

// File: rtl/lldma_dpath.sv
module lldma_dpath
  import lldma_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] startAddr,
  input  logic [1:0]        unitSize,
  input  dpStrobe_t         strb,
  output dpStatus_t         stat,
  output logic [WORD_W-1:0] descRdAddr,
  input  logic [WORD_W-1:0] descRdData,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] devAddr,
  output logic [WORD_W-1:0] wrData,
  input  logic [WORD_W-1:0] memRdata,
  input  logic [WORD_W-1:0] devRdata
);
  localparam int BASE_W = WORD_W - ALIGN_BITS;

  logic [BASE_W-1:0] baseQ;
  logic [IDX_W-1:0]  idxQ;
  logic [WORD_W-1:0] nextQ, srcQ, dstQ, strideQ, dataQ, memPtrQ, devPtrQ;
  logic [LEN_W-1:0]  lenQ, cycQ, unitLeftQ, blockLeftQ;
  logic              toDevQ, irqReqQ, irqMaskQ;
  logic [WORD_W-1:0] unitBytes;
  logic              unusedBits;

  assign unitBytes = (unitSize == 2'd0) ? WORD_W'(1) :
                     (unitSize == 2'd1) ? WORD_W'(2) : WORD_W'(4);
  assign unusedBits = ^{startAddr[ALIGN_BITS-1:0], nextQ[ALIGN_BITS-1:1]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0; idxQ <= '0; nextQ <= '0; srcQ <= '0; dstQ <= '0;
      strideQ <= '0; dataQ <= '0; memPtrQ <= '0; devPtrQ <= '0;
      lenQ <= '0; cycQ <= '0; unitLeftQ <= '0; blockLeftQ <= '0;
      toDevQ <= 1'b0; irqReqQ <= 1'b0; irqMaskQ <= 1'b0;
    end else begin
      if (strb.loadBase) begin
        baseQ <= startAddr[WORD_W-1:ALIGN_BITS];
        idxQ  <= '0;
      end else if (strb.loadNext) begin
        baseQ <= nextQ[WORD_W-1:ALIGN_BITS];
        idxQ  <= '0;
      end else if (strb.capWord) begin
        idxQ <= idxQ + IDX_W'(1);
        case (idxQ)
          3'd0: nextQ   <= descRdData;
          3'd1: srcQ    <= descRdData;
          3'd2: dstQ    <= descRdData;
          3'd3: lenQ    <= descRdData[LEN_W-1:0];
          3'd4: strideQ <= descRdData;
          3'd5: cycQ    <= descRdData[LEN_W-1:0];
          default: begin
            toDevQ     <= descRdData[CMD_TODEV];
            irqReqQ    <= descRdData[CMD_IRQ_REQ];
            irqMaskQ   <= descRdData[CMD_IRQ_MASK];
            memPtrQ    <= descRdData[CMD_TODEV] ? srcQ : dstQ;
            devPtrQ    <= descRdData[CMD_TODEV] ? dstQ : srcQ;
            unitLeftQ  <= lenQ;
            blockLeftQ <= (cycQ == '0) ? LEN_W'(1) : cycQ;
          end
        endcase
      end
      if (strb.capData) dataQ <= toDevQ ? memRdata : devRdata;
      if (strb.stepUnit) begin
        if (unitLeftQ == LEN_W'(1) && blockLeftQ != LEN_W'(1)) begin
          memPtrQ    <= memPtrQ + unitBytes + strideQ;
          unitLeftQ  <= lenQ;
          blockLeftQ <= blockLeftQ - LEN_W'(1);
        end else begin
          memPtrQ   <= memPtrQ + unitBytes;
          unitLeftQ <= unitLeftQ - LEN_W'(1);
        end
      end
    end
  end

  assign descRdAddr = {baseQ, ALIGN_BITS'({idxQ, 2'b00})};
  assign memAddr    = memPtrQ;
  assign devAddr    = devPtrQ;
  assign wrData     = dataQ;

  assign stat.lastWord  = (idxQ == IDX_W'(DESC_WORDS - 1));
  assign stat.noUnits   = (unitLeftQ == '0);
  assign stat.lastUnit  = (unitLeftQ == LEN_W'(1));
  assign stat.lastBlock = (blockLeftQ == LEN_W'(1));
  assign stat.toDev     = toDevQ;
  assign stat.irqEn     = irqReqQ & ~irqMaskQ;
  assign stat.nextValid = nextQ[NEXT_OK];
endmodule

// File: rtl/lldma_ctrl.sv
module lldma_ctrl
  import lldma_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startPulse,
  input  logic      stopPulse,
  input  dpStatus_t stat,
  input  logic      descRdValid,
  input  logic      memAck,
  input  logic      devAck,
  output dpStrobe_t strb,
  output logic      busy,
  output logic      irq,
  output logic      descRdReq,
  output logic      memReq,
  output logic      memWe,
  output logic      devReq,
  output logic      devWe
);
  chanState_t stateQ, stateNext;
  logic stopPendQ, stopNow, srcAck, dstAck;

  assign stopNow = stopPendQ | stopPulse;
  assign srcAck  = stat.toDev ? memAck : devAck;
  assign dstAck  = stat.toDev ? devAck : memAck;

  always_comb begin
    stateNext = stateQ;
    strb      = '0;
    case (stateQ)
      ST_IDLE: if (startPulse) begin
        strb.loadBase = 1'b1;
        stateNext     = ST_FETCH;
      end
      ST_FETCH: if (descRdValid) begin
        strb.capWord = 1'b1;
        if (stopNow)            stateNext = ST_IDLE;
        else if (stat.lastWord) stateNext = ST_CHECK;
      end
      ST_CHECK:
        if (stopNow)           stateNext = ST_IDLE;
        else if (stat.noUnits) stateNext = ST_DONE;
        else                   stateNext = ST_READ;
      ST_READ: if (srcAck) begin
        strb.capData = 1'b1;
        stateNext    = ST_WRITE;
      end
      ST_WRITE: if (dstAck) begin
        strb.stepUnit = 1'b1;
        if (stopNow)                             stateNext = ST_IDLE;
        else if (stat.lastUnit && stat.lastBlock) stateNext = ST_DONE;
        else                                     stateNext = ST_READ;
      end
      ST_DONE:
        if (stat.nextValid && !stopNow) begin
          strb.loadNext = 1'b1;
          stateNext     = ST_FETCH;
        end else begin
          stateNext = ST_IDLE;
        end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      stopPendQ <= 1'b0;
    end else begin
      stateQ <= stateNext;
      if (stateNext == ST_IDLE) stopPendQ <= 1'b0;
      else if (stopPulse)       stopPendQ <= 1'b1;
    end
  end

  assign busy      = (stateQ != ST_IDLE);
  assign irq       = (stateQ == ST_DONE) && stat.irqEn;
  assign descRdReq = (stateQ == ST_FETCH);
  assign memReq    = ((stateQ == ST_READ) && stat.toDev) || ((stateQ == ST_WRITE) && !stat.toDev);
  assign memWe     = (stateQ == ST_WRITE) && !stat.toDev;
  assign devReq    = ((stateQ == ST_READ) && !stat.toDev) || ((stateQ == ST_WRITE) && stat.toDev);
  assign devWe     = (stateQ == ST_WRITE) && stat.toDev;
endmodule

// File: rtl/lldma_chan.sv
module lldma_chan
  import lldma_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startPulse,
  input  logic        stopPulse,
  input  logic [31:0] startAddr,
  input  logic [1:0]  unitSize,
  output logic        busy,
  output logic        irq,
  output logic        descRdReq,
  output logic [31:0] descRdAddr,
  input  logic        descRdValid,
  input  logic [31:0] descRdData,
  output logic        memReq,
  output logic        memWe,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata,
  input  logic [31:0] memRdata,
  input  logic        memAck,
  output logic        devReq,
  output logic        devWe,
  output logic [31:0] devAddr,
  output logic [31:0] devWdata,
  input  logic [31:0] devRdata,
  input  logic        devAck
);
  dpStrobe_t strb;
  dpStatus_t stat;
  logic [WORD_W-1:0] wrData;

  lldma_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .stopPulse(stopPulse),
    .stat(stat), .descRdValid(descRdValid), .memAck(memAck), .devAck(devAck),
    .strb(strb), .busy(busy), .irq(irq), .descRdReq(descRdReq),
    .memReq(memReq), .memWe(memWe), .devReq(devReq), .devWe(devWe)
  );

  lldma_dpath #(.LEN_W(LEN_W)) uDpath (
    .clk(clk), .rstN(rstN), .startAddr(startAddr), .unitSize(unitSize),
    .strb(strb), .stat(stat), .descRdAddr(descRdAddr), .descRdData(descRdData),
    .memAddr(memAddr), .devAddr(devAddr), .wrData(wrData),
    .memRdata(memRdata), .devRdata(devRdata)
  );

  assign memWdata = wrData;
  assign devWdata = wrData;
endmodule

// File: rtl/lldma_chan_chk.sv
module lldma_chan_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        irq,
  input logic        descRdReq,
  input logic [31:0] descRdAddr,
  input logic        descRdValid,
  input logic        memReq,
  input logic        memWe,
  input logic [31:0] memAddr,
  input logic        memAck,
  input logic        devReq,
  input logic        devWe,
  input logic [31:0] devAddr,
  input logic        devAck
);
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!descRdReq && !memReq && !devReq && !irq));

  // R12
  desc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (descRdReq && !descRdValid) |=> (descRdReq && $stable(descRdAddr)));

  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe)));

  // R12
  dev_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (devReq && !devAck) |=> (devReq && $stable(devAddr) && $stable(devWe)));

  // R12
  one_port_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memReq && devReq));

  // R8
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

  // R1
  desc_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    descRdReq |-> (descRdAddr[1:0] == 2'b00 && descRdAddr[5:0] <= 6'd24));
endmodule

bind lldma_chan lldma_chan_chk uChk (
  .clk(clk), .rstN(rstN), .busy(busy), .irq(irq),
  .descRdReq(descRdReq), .descRdAddr(descRdAddr), .descRdValid(descRdValid),
  .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memAck(memAck),
  .devReq(devReq), .devWe(devWe), .devAddr(devAddr), .devAck(devAck)
);

// File: tb/sim_lldma_chan.sv
module sim_lldma_chan;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic startPulse = 1'b0, stopPulse = 1'b0;
  logic [31:0] startAddr = '0;
  logic [1:0] unitSize = 2'd2;
  logic busy, irq, descRdReq, memReq, memWe, devReq, devWe;
  logic [31:0] descRdAddr, memAddr, memWdata, devAddr, devWdata;
  logic descRdValid, memAck, devAck;
  logic [31:0] descRdData, memRdata, devRdata;

  lldma_chan u0 (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .stopPulse(stopPulse),
    .startAddr(startAddr), .unitSize(unitSize), .busy(busy), .irq(irq),
    .descRdReq(descRdReq), .descRdAddr(descRdAddr), .descRdValid(descRdValid),
    .descRdData(descRdData), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck), .devReq(devReq),
    .devWe(devWe), .devAddr(devAddr), .devWdata(devWdata), .devRdata(devRdata),
    .devAck(devAck)
  );

  // Responders and logs
  logic [31:0] descMem [512];
  logic [31:0] dataMem [512];
  logic clrLogs = 1'b0;
  int descCnt, memCnt, devCnt, irqRise, irqCycles;
  logic irqPrev;
  logic [31:0] descLogA [64];
  logic [31:0] memLogA [64], memLogD [64], devLogA [64], devLogD [64];
  logic memLogW [64], devLogW [64];

  always @(posedge clk) begin
    if (!rstN) begin
      descRdValid <= 1'b0; memAck <= 1'b0; devAck <= 1'b0;
      descRdData <= '0; memRdata <= '0; devRdata <= '0;
      for (int i = 0; i < 512; i++) dataMem[i] <= 32'hC0DE_0000 | i;
      descCnt <= 0; memCnt <= 0; devCnt <= 0; irqRise <= 0; irqCycles <= 0; irqPrev <= 1'b0;
    end else if (clrLogs) begin
      descCnt <= 0; memCnt <= 0; devCnt <= 0; irqRise <= 0; irqCycles <= 0;
      irqPrev <= irq;
    end else begin
      descRdValid <= 1'b0; memAck <= 1'b0; devAck <= 1'b0;
      irqPrev <= irq;
      if (irq) irqCycles <= irqCycles + 1;
      if (irq && !irqPrev) irqRise <= irqRise + 1;
      if (descRdReq && !descRdValid) begin
        descRdValid <= 1'b1;
        descRdData  <= descMem[descRdAddr[10:2]];
        if (descCnt < 64) descLogA[descCnt] <= descRdAddr;
        descCnt <= descCnt + 1;
      end
      if (memReq && !memAck) begin
        memAck <= 1'b1;
        if (memCnt < 64) begin
          memLogA[memCnt] <= memAddr;
          memLogW[memCnt] <= memWe;
          memLogD[memCnt] <= memWe ? memWdata : dataMem[memAddr[10:2]];
        end
        if (memWe) dataMem[memAddr[10:2]] <= memWdata;
        else       memRdata <= dataMem[memAddr[10:2]];
        memCnt <= memCnt + 1;
      end
      if (devReq && !devAck) begin
        devAck <= 1'b1;
        if (devCnt < 64) begin
          devLogA[devCnt] <= devAddr;
          devLogW[devCnt] <= devWe;
          devLogD[devCnt] <= devWe ? devWdata : (32'hA500_0000 | devCnt);
        end
        if (!devWe) devRdata <= 32'hA500_0000 | devCnt;
        devCnt <= devCnt + 1;
      end
    end
  end

  int tests = 0, fails = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic putDesc(input logic [31:0] base, input logic [31:0] nxt, input logic [31:0] src,
                         input logic [31:0] dst, input logic [31:0] len, input logic [31:0] stride,
                         input logic [31:0] cyc, input logic [31:0] cmd);
    descMem[base[10:2] + 0] = nxt;
    descMem[base[10:2] + 1] = src;
    descMem[base[10:2] + 2] = dst;
    descMem[base[10:2] + 3] = len;
    descMem[base[10:2] + 4] = stride;
    descMem[base[10:2] + 5] = cyc;
    descMem[base[10:2] + 6] = cmd;
  endtask

  task automatic clearLogs();
    @(negedge clk) clrLogs = 1'b1;
    @(negedge clk) clrLogs = 1'b0;
  endtask

  task automatic kick(input logic [31:0] a);
    @(negedge clk) begin startAddr = a; startPulse = 1'b1; end
    @(negedge clk) startPulse = 1'b0;
  endtask

  task automatic halt();
    @(negedge clk) stopPulse = 1'b1;
    @(negedge clk) stopPulse = 1'b0;
  endtask

  task automatic waitIdle();
    repeat (2) @(negedge clk);
    for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
  endtask

  localparam logic [31:0] BUF  = 32'h0000_0400;
  localparam logic [31:0] DEVA = 32'h8000_0010;
  // dir, unitSize, len, cycles, stride, {irqReq, irqMask}
  localparam logic [28:0] VEC [6] = '{
    {1'b1, 2'd2, 8'd4, 8'd1, 8'd0, 2'b10},
    {1'b0, 2'd0, 8'd5, 8'd1, 8'd0, 2'b10},
    {1'b1, 2'd1, 8'd3, 8'd2, 8'd8, 2'b10},
    {1'b0, 2'd2, 8'd2, 8'd0, 8'd0, 2'b11},
    {1'b1, 2'd3, 8'd2, 8'd3, 8'd4, 2'b00},
    {1'b1, 2'd2, 8'd0, 8'd1, 8'd0, 2'b10}
  };

  initial begin
    repeat (3000) @(negedge clk);
    for (int i = 0; i < 20000; i++) @(negedge clk);
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) descMem[i] = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    check(!busy && !irq, "R11 idle after reset", {busy, irq}, 0);
    check(!descRdReq && !memReq && !devReq, "R11 no requests", {descRdReq, memReq, devReq}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !descRdReq, "R11 stays idle", {busy, descRdReq}, 0);

    foreach (VEC[v]) begin
      logic dir; logic [1:0] us; int len, cyc, stride, ub, n, j, expIrq;
      logic [31:0] cmd; bit ok;
      dir = VEC[v][28]; us = VEC[v][27:26]; len = VEC[v][25:18];
      cyc = VEC[v][17:10]; stride = VEC[v][9:2];
      cmd = (dir ? 32'h1000 : 32'h0) | VEC[v][1:0];
      putDesc(32'h40, 32'h0, dir ? BUF : DEVA, dir ? DEVA : BUF, len, stride, cyc, cmd);
      unitSize = us;
      clearLogs();
      kick(32'h6B);
      waitIdle();
      ub = (us == 0) ? 1 : (us == 1) ? 2 : 4;
      n = len * ((cyc == 0) ? 1 : cyc);
      ok = (descCnt == 7);
      for (int i = 0; i < 7; i++) if (descLogA[i] != 32'h40 + 4*i) ok = 0;
      check(ok, "R1 fetch order and alignment", descCnt, 7);
      check(memCnt == n && devCnt == n, (len == 0) ? "R5 zero length" : "R3 unit count", memCnt, n);
      ok = 1; j = 0;
      for (int b = 0; b < ((cyc == 0) ? 1 : cyc); b++)
        for (int k = 0; k < len; k++) begin
          if (memLogA[j] != BUF + b*(len*ub + stride) + k*ub) ok = 0;
          if (devLogA[j] != DEVA) ok = 0;
          j++;
        end
      check(ok, (cyc > 1) ? "R4 stride blocks" : "R3 address steps", j, n);
      ok = 1;
      for (int i = 0; i < n; i++)
        if (memLogW[i] == dir || devLogW[i] != dir || memLogD[i] != devLogD[i]) ok = 0;
      check(ok, "R2 direction and data", dir, dir);
      expIrq = (VEC[v][1:0] == 2'b10) ? 1 : 0;
      check(irqRise == expIrq && irqCycles == expIrq, "R8 irq gating and width", irqCycles, expIrq);
    end

    // R6: chaining, then stop on clear valid bit
    unitSize = 2'd2;
    putDesc(32'h40, 32'h81, BUF, DEVA, 2, 0, 1, 32'h1002);
    putDesc(32'h80, 32'hC0, DEVA, BUF, 3, 0, 1, 32'h0002);
    clearLogs(); kick(32'h40); waitIdle();
    check(descCnt == 14 && descLogA[7] == 32'h80, "R6 chain follow", descLogA[7], 32'h80);
    check(memCnt == 5 && devCnt == 5 && irqRise == 2 && !busy, "R6 chain end", irqRise, 2);

    // R7: ring loops until stopped
    putDesc(32'h40, 32'h81, BUF, DEVA, 1, 0, 1, 32'h1002);
    putDesc(32'h80, 32'h41, BUF, DEVA, 1, 0, 1, 32'h1002);
    clearLogs(); kick(32'h40);
    for (int i = 0; i < 3000 && irqRise < 5; i++) @(negedge clk);
    halt(); waitIdle();
    check(irqRise >= 5 && descLogA[14] == 32'h40, "R7 ring wraps", descLogA[14], 32'h40);
    check(!busy, "R9 ring stopped", busy, 0);

    // R9: stop mid transfer
    putDesc(32'h40, 32'h81, BUF, DEVA, 20, 0, 1, 32'h1002);
    clearLogs(); kick(32'h40);
    for (int i = 0; i < 3000 && devCnt < 3; i++) @(negedge clk);
    halt(); waitIdle();
    repeat (20) @(negedge clk);
    check(devCnt == memCnt && devCnt < 20, "R9 unit completes then parks", devCnt, memCnt);
    check(irqRise == 0 && descCnt == 7, "R9 no irq no fetch", descCnt, 7);

    // R10: start while busy ignored
    putDesc(32'h40, 32'h0, BUF, DEVA, 4, 0, 1, 32'h1002);
    putDesc(32'h80, 32'h0, BUF, DEVA, 9, 0, 1, 32'h1002);
    clearLogs(); kick(32'h40);
    repeat (10) @(negedge clk);
    kick(32'h80); waitIdle();
    check(descCnt == 7 && devCnt == 4 && descLogA[0] == 32'h40, "R10 start while busy", devCnt, 4);

    // R10: stop while idle ignored
    clearLogs(); halt();
    repeat (5) @(negedge clk);
    check(!busy && descCnt == 0, "R10 stop idle no effect", descCnt, 0);
    kick(32'h40); waitIdle();
    check(devCnt == 4 && irqRise == 1, "R10 no pending stop", devCnt, 4);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule